// File: doc/BRIEF.md
# Single-Word Peripheral-to-Memory Mover

This block copies one data word from a peripheral register into a memory location while the processor keeps running its own program. Software first writes two addresses into the block: where the word comes from and where it goes. From then on, the peripheral only has to raise its transfer request. The block asks the processor for the system bus and waits until the processor hands the bus over. It then acknowledges the peripheral, performs one read bus cycle at the source address and one write bus cycle at the destination address, and gives the bus back.

The block talks to three parties. The peripheral sees a request/acknowledge pair. The processor sees a bus-hold request/grant pair. A simple bus master port carries an address, an enable, a read/write select, read data and write data. The block drives all of its outputs from registers. The word taken during the read cycle is held inside the block and presented during the write cycle that follows.

Top module: `xfer_dma`

## Requirements
- R1: After a synchronous active-high reset, `hold_req`, `xfer_ack`, `m_en` and `m_wr` are all 0.
- R2: Suppose the block is idle and `xfer_req` is 1 at a rising edge. Then `hold_req` is 1 after that edge and stays 1 until the transfer completes.
- R3: `m_en` stays 0 until `hold_gnt` has been seen high with `hold_req` high, and it is never 1 while `hold_gnt` is 0.
- R4: `xfer_ack` and a read cycle both start on the first edge after the grant is seen. The read cycle has `m_en`=1, `m_wr`=0 (0 means read, 1 means write) and `m_addr` equal to the source register.
- R5: The cycle right after the read cycle is a write cycle, with `m_en`=1, `m_wr`=1 and `m_addr` equal to the destination register.
- R6: During the write cycle, `m_wdata` equals the `m_rdata` value that was present during the read cycle. As a result, the destination location holds the source word afterwards.
- R7: On the edge that ends the write cycle, `hold_req`, `xfer_ack` and `m_en` all return to 0.
- R8: A new transfer can start only after `xfer_req` and `hold_gnt` have both been seen low since the previous transfer ended. While `xfer_req` stays high, `hold_req` stays 0.
- R9: A configuration write with `cfg_we`=1 loads the source register when `cfg_sel`=0 and the destination register when `cfg_sel`=1. Such a write is ignored while a transfer is in progress (from the request until the return to idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the source register, 1 selects the destination register |
| cfg_wdata | input | AW | Address value to load |
| xfer_req | input | 1 | Peripheral asks for a transfer |
| xfer_ack | output | 1 | Acknowledge to the peripheral while the block owns the bus |
| hold_req | output | 1 | Request for system bus ownership |
| hold_gnt | input | 1 | Processor has released the bus to the block |
| m_addr | output | AW | Bus master address |
| m_wr | output | 1 | 0 = read cycle, 1 = write cycle |
| m_en | output | 1 | Bus cycle enable |
| m_rdata | input | DW | Read data from the bus, valid in the same cycle as the read |
| m_wdata | output | DW | Write data driven during the write cycle |

## Verification
The assertions rely on the processor behaving well. It raises `hold_gnt` only after seeing `hold_req`, and it keeps `hold_gnt` high until `hold_req` has fallen. The memory must also return read data combinationally, within the read cycle. The bench models the processor side as a task that holds the grant back for a few cycles after the request and releases it only after the request drops. Its memory model answers reads from an array indexed by the current address, so both conditions hold for every transfer it starts.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ASK  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/xfer_dma_cfg.sv
module xfer_dma_cfg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0;
      dst_addr <= '0;
    end else if (wr_ok) begin
      if (cfg_sel) dst_addr <= cfg_wdata;
      else         src_addr <= cfg_wdata;
    end
  end

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_we) |=> ($stable(src_addr) && $stable(dst_addr))); // R9
endmodule

// File: rtl/xfer_dma_seq.sv
module xfer_dma_seq
  import xfer_dma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_req,
  input  logic hold_gnt,
  output logic hold_req,
  output logic xfer_ack,
  output logic issue_rd,
  output logic issue_wr,
  output logic finish,
  output logic busy
);
  seq_state_t state, state_nx;

  assign issue_rd = (state == ST_ASK) && hold_gnt;
  assign issue_wr = (state == ST_RD);
  assign finish   = (state == ST_WR);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (xfer_req) state_nx = ST_ASK;
      ST_ASK:  if (hold_gnt) state_nx = ST_RD;
      ST_RD:   state_nx = ST_WR;
      ST_WR:   state_nx = ST_DONE;
      ST_DONE: if (!xfer_req && !hold_gnt) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hold_req <= 1'b0;
      xfer_ack <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && xfer_req) hold_req <= 1'b1;
      else if (finish)                  hold_req <= 1'b0;
      if (issue_rd)    xfer_ack <= 1'b1;
      else if (finish) xfer_ack <= 1'b0;
    end
  end

  AST_ACK_INSIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> hold_req); // R4
  AST_NO_QUICK_REARM: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_req) |=> !hold_req); // R8
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    (hold_req && state != ST_WR) |=> hold_req); // R2
endmodule

// File: rtl/xfer_dma_bus.sv
module xfer_dma_bus #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_rd,
  input  logic          issue_wr,
  input  logic          finish,
  input  logic          hold_gnt,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [DW-1:0] m_rdata,
  output logic [AW-1:0] m_addr,
  output logic          m_wr,
  output logic          m_en,
  output logic [DW-1:0] m_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_addr  <= '0;
      m_wr    <= 1'b0;
      m_en    <= 1'b0;
      m_wdata <= '0;
    end else if (issue_rd) begin
      m_addr <= src_addr;
      m_wr   <= 1'b0;
      m_en   <= 1'b1;
    end else if (issue_wr) begin
      m_addr  <= dst_addr;
      m_wr    <= 1'b1;
      m_wdata <= m_rdata;
    end else if (finish) begin
      m_addr  <= '0;
      m_wr    <= 1'b0;
      m_en    <= 1'b0;
      m_wdata <= '0;
    end
  end

  AST_EN_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    m_en |-> hold_gnt); // R3
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    (m_en && m_wr) |-> $past(m_en && !m_wr)); // R5
  AST_WDATA_FROM_RD: assert property (@(posedge clk) disable iff (rst)
    (m_en && m_wr) |-> (m_wdata == $past(m_rdata))); // R6
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (m_en && m_wr) |=> !m_en); // R7
endmodule

// File: rtl/xfer_dma.sv
module xfer_dma #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          xfer_req,
  output logic          xfer_ack,
  output logic          hold_req,
  input  logic          hold_gnt,
  output logic [AW-1:0] m_addr,
  output logic          m_wr,
  output logic          m_en,
  input  logic [DW-1:0] m_rdata,
  output logic [DW-1:0] m_wdata
);
  logic [AW-1:0] src_addr, dst_addr;
  logic issue_rd, issue_wr, finish, busy;

  xfer_dma_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  xfer_dma_seq u_seq (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .hold_gnt(hold_gnt),
    .hold_req(hold_req), .xfer_ack(xfer_ack), .issue_rd(issue_rd),
    .issue_wr(issue_wr), .finish(finish), .busy(busy)
  );

  xfer_dma_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .issue_rd(issue_rd), .issue_wr(issue_wr),
    .finish(finish), .hold_gnt(hold_gnt), .src_addr(src_addr),
    .dst_addr(dst_addr), .m_rdata(m_rdata), .m_addr(m_addr),
    .m_wr(m_wr), .m_en(m_en), .m_wdata(m_wdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!hold_req && !xfer_ack && !m_en)); // R1
endmodule

// File: tb/xfer_dma_bench.sv
module xfer_dma_bench;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic xfer_req = 1'b0, hold_gnt = 1'b0;
  logic xfer_ack, hold_req, m_wr, m_en;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_rdata, m_wdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem [0:255];
  logic [AW+DW-1:0] exp_q [$];

  always #10 clk = ~clk;

  function automatic int idx(input logic [AW-1:0] a);
    return {a[15], a[6:0]};
  endfunction

  assign m_rdata = mem[idx(m_addr)];
  always @(posedge clk) if (m_en && m_wr) mem[idx(m_addr)] <= m_wdata;

  xfer_dma #(.AW(AW), .DW(DW)) u_xfer_dma (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .hold_req(hold_req), .hold_gnt(hold_gnt), .m_addr(m_addr),
    .m_wr(m_wr), .m_en(m_en), .m_rdata(m_rdata), .m_wdata(m_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each write cycle pops one expected {addr,data}
  always @(negedge clk) begin
    if (!rst && m_en && m_wr) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected write", int'(m_addr), 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk(m_addr == e[AW+DW-1:DW], "R5 write address", int'(m_addr), int'(e[AW+DW-1:DW]));
        chk(m_wdata == e[DW-1:0], "R6 write data", int'(m_wdata), int'(e[DW-1:0]));
      end
    end
  end

  task automatic cfg_write(input logic sel, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input logic [DW-1:0] val, input int gnt_delay,
                          input bit poke_cfg, input bit keep_req);
    mem[idx(src)] = val;
    exp_q.push_back({dst, val});
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    chk(hold_req == 1'b1, "R2 hold request", int'(hold_req), 1);
    if (poke_cfg) begin
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h0055;
    end
    for (int i = 0; i < gnt_delay; i++) begin
      chk(m_en == 1'b0 && xfer_ack == 1'b0, "R3 no bus before grant", int'(m_en), 0);
      chk(hold_req == 1'b1, "R2 request held", int'(hold_req), 1);
      @(negedge clk);
      cfg_we = 1'b0;
    end
    cfg_we = 1'b0;
    hold_gnt = 1'b1;
    @(negedge clk);
    chk(xfer_ack == 1'b1, "R4 ack with read", int'(xfer_ack), 1);
    chk(m_en && !m_wr, "R4 read cycle", int'({m_en, m_wr}), 2);
    chk(m_addr == src, "R4 read address", int'(m_addr), int'(src));
    @(negedge clk);  // write cycle, checked by the monitor
    @(negedge clk);
    chk(!hold_req && !xfer_ack && !m_en, "R7 release", int'({hold_req, xfer_ack, m_en}), 0);
    chk(mem[idx(dst)] == val, "R6 memory content", int'(mem[idx(dst)]), int'(val));
    if (!keep_req) xfer_req = 1'b0;
    @(negedge clk);
    hold_gnt = 1'b0;
    if (keep_req) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(hold_req == 1'b0, "R8 no restart while request high", int'(hold_req), 0);
      end
      xfer_req = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!hold_req && !xfer_ack && !m_en && !m_wr, "R1 reset outputs",
        int'({hold_req, xfer_ack, m_en, m_wr}), 0);
    rst = 1'b0;
    // R9: cfg_sel 0 = source, 1 = destination
    cfg_write(1'b0, 16'h8000);
    cfg_write(1'b1, 16'h0001);
    run_xfer(16'h8000, 16'h0001, 16'h064C, 2, 1'b0, 1'b0);
    run_xfer(16'h8000, 16'h0001, 16'hA5A5, 0, 1'b0, 1'b0);
    // R9: destination write during a transfer is ignored, now and later
    run_xfer(16'h8000, 16'h0001, 16'h1234, 3, 1'b1, 1'b0);
    run_xfer(16'h8000, 16'h0001, 16'h4321, 1, 1'b0, 1'b0);
    cfg_write(1'b0, 16'h8007);
    cfg_write(1'b1, 16'h0042);
    // R8: request kept high after completion
    run_xfer(16'h8007, 16'h0042, 16'hFFFF, 1, 1'b0, 1'b1);
    run_xfer(16'h8007, 16'h0042, 16'h0000, 5, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
    chk(hold_req == 1'b0, "R8 idle at end", int'(hold_req), 0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end
endmodule